// File: doc/BRIEF.md
# Dual Converter Mode Coordinator

This block links two analog-to-digital converter sequencers, one acting as master and one as slave. It takes the master's trigger and issues start pulses to both converters according to a selected dual mode. In simultaneous mode both converters start together and their two 12-bit results are merged into one 32-bit word. In fast or slow interleaved mode the slave starts first and the master follows after a fixed number of converter-clock ticks. Mode 0 leaves each converter independent, and each converter's own trigger is passed through.

A DMA-style reader consumes `dma_word` whenever `dma_req` pulses. The converter clock is represented by `conv_tick`, a one-cycle enable. Every spacing is counted only in cycles where this enable is high. A trigger that arrives while a dual operation is still running is lost and sets a sticky flag. A slow interleaved request for a regular group longer than one channel is refused and sets a separate sticky flag.

Top module: `dual_adc_coord`

## Requirements
- R1: After reset, `mst_start`, `slv_start`, `dma_req`, `missed` and `cfg_err` are all 0.
- R2: With `mode`=0 and no dual operation running, `mst_start` and `slv_start` each follow their own trigger one cycle later. `dma_req` stays 0 for the results of those conversions.
- R3: With `mode`=1, a `mst_trig` accepted at a clock edge raises `slv_start` and `mst_start` together in the following cycle.
- R4: In mode 1, `dma_req` pulses once per operation, in the cycle after the edge that follows the later of the two done pulses. `dma_word` holds the master result in bits 11:0 and the slave result in bits 27:16, with bits 15:12 and 31:28 zero.
- R5: With `mode`=2, the slave starts in the cycle after the accepted trigger. The master start appears in the cycle after the edge where the 7th `conv_tick` is counted. Counting begins at the first edge after the slave start.
- R6: With `mode`=3, the same rule applies with 14 counted ticks instead of 7.
- R7: With `mode`=3, a trigger while `seq_len_m1` is not 0 starts nothing and sets `cfg_err`, which stays 1 until reset.
- R8: In modes 2 and 3, each result yields its own `dma_req` pulse one cycle after its done edge, with the result in bits 11:0 and bits 31:12 zero. When both done pulses fall on the same edge, the slave word goes out first and the master word follows one cycle later.
- R9: A trigger is dropped at any edge from acceptance up to and including the edge that emits the operation's last word. The dropped trigger sets `missed`, which stays 1 until reset. In mode 0 either trigger counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_tick | input | 1 | Converter-clock enable, one pulse per converter cycle |
| mode | input | 2 | 0 independent, 1 simultaneous, 2 fast interleaved, 3 slow interleaved |
| seq_len_m1 | input | 4 | Regular group length minus one |
| mst_trig | input | 1 | Master trigger pulse |
| slv_trig | input | 1 | Slave trigger pulse (independent mode only) |
| mst_start | output | 1 | Start pulse to the master converter |
| slv_start | output | 1 | Start pulse to the slave converter |
| mst_done | input | 1 | Master conversion complete pulse |
| mst_res | input | 12 | Master conversion result |
| slv_done | input | 1 | Slave conversion complete pulse |
| slv_res | input | 12 | Slave conversion result |
| dma_req | output | 1 | One-cycle data-ready strobe |
| dma_word | output | 32 | Data word valid while `dma_req` is 1 |
| missed | output | 1 | Sticky dropped-trigger flag |
| cfg_err | output | 1 | Sticky refused slow-mode request flag |

## Verification
The hardest case to reach from the ports is the interleaved collision, where both done pulses fall on the same edge and the coordinator has to hold one result for a cycle. The bench's responders use latencies that vary with the start edge. One fast-mode trigger is placed at an edge where the slave's latency equals the master's latency plus the 7-tick gap. A window where `conv_tick` toggles every other cycle shows that spacing counts ticks and not clock cycles. Triggers placed on the final emission edge and the edge after it probe the exact end of the busy window.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int RES_W  = 12;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    DM_SOLO  = 2'd0,
    DM_SIMUL = 2'd1,
    DM_FAST  = 2'd2,
    DM_SLOW  = 2'd3
  } dual_mode_e;

  // both results side by side: master low half, slave high half
  function automatic logic [WORD_W-1:0] pack_pair(input logic [RES_W-1:0] lo,
                                                  input logic [RES_W-1:0] hi);
    return {{(HALF_W-RES_W){1'b0}}, hi, {(HALF_W-RES_W){1'b0}}, lo};
  endfunction

  // one result right-justified in the word
  function automatic logic [WORD_W-1:0] lone_word(input logic [RES_W-1:0] r);
    return {{(WORD_W-RES_W){1'b0}}, r};
  endfunction

  function automatic int gap_for(input dual_mode_e m, input int fast_gap, input int slow_gap);
    return (m == DM_SLOW) ? slow_gap : fast_gap;
  endfunction
endpackage

// File: rtl/dcc_spacer.sv
module dcc_spacer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] gap,
  input  logic             tick,
  output logic             hit
);
  logic             active;
  logic [CNT_W-1:0] remain;

  assign hit = active && tick && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (load) begin
      active <= 1'b1;
      remain <= gap;
    end else if (active && tick) begin
      if (remain == CNT_W'(1)) active <= 1'b0;
      else                     remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dcc_collect.sv
module dcc_collect
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              busy,
  input  logic              packed_op,
  input  logic              mst_done,
  input  logic [RES_W-1:0]  mst_res,
  input  logic              slv_done,
  input  logic [RES_W-1:0]  slv_res,
  output logic              dma_req,
  output logic [WORD_W-1:0] dma_word,
  output logic              last
);
  localparam int LANES = 2; // lane 0 master, lane 1 slave

  logic [LANES-1:0] done_in, got, vld, sent, drain;
  logic [RES_W-1:0] res_in [LANES];
  logic [RES_W-1:0] cap    [LANES];
  logic             fire_pair, fire_s, fire_m;

  assign done_in   = {slv_done, mst_done};
  assign res_in[0] = mst_res;
  assign res_in[1] = slv_res;

  assign fire_pair = packed_op && vld[0] && vld[1];
  assign fire_s    = !packed_op && vld[1];
  assign fire_m    = !packed_op && !vld[1] && vld[0];
  assign drain     = {fire_pair || fire_s, fire_pair || fire_m};
  assign last      = fire_pair || (fire_s && sent[0]) || (fire_m && sent[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got  <= '0;
      vld  <= '0;
      sent <= '0;
      for (int i = 0; i < LANES; i++) cap[i] <= '0;
    end else if (arm) begin
      got  <= '0;
      vld  <= '0;
      sent <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (busy && done_in[i] && !got[i]) begin
          got[i] <= 1'b1;
          vld[i] <= 1'b1;
          cap[i] <= res_in[i];
        end else if (drain[i]) begin
          vld[i] <= 1'b0;
        end
      end
      sent <= sent | {fire_s, fire_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req  <= 1'b0;
      dma_word <= '0;
    end else begin
      dma_req <= fire_pair || fire_s || fire_m;
      if (fire_pair)   dma_word <= pack_pair(cap[0], cap[1]);
      else if (fire_s) dma_word <= lone_word(cap[1]);
      else if (fire_m) dma_word <= lone_word(cap[0]);
    end
  end
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int SEQ_W    = 4,
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [SEQ_W-1:0] seq_len_m1,
  input  logic             mst_trig,
  input  logic             slv_trig,
  input  logic             hit,
  input  logic             last,
  output logic             mst_start,
  output logic             slv_start,
  output logic             missed,
  output logic             cfg_err,
  output logic             busy,
  output dual_mode_e       op_mode,
  output logic             arm,
  output logic             spc_load,
  output logic [CNT_W-1:0] spc_gap
);
  typedef enum logic [1:0] {ST_IDLE, ST_SPACE, ST_RUN} st_e;
  st_e        st;
  dual_mode_e req_mode;
  logic       any_trig, solo, bad_len, drop_busy;

  assign req_mode  = dual_mode_e'(mode);
  assign busy      = (st != ST_IDLE);
  assign any_trig  = (req_mode == DM_SOLO) ? (mst_trig || slv_trig) : mst_trig;
  assign drop_busy = busy && any_trig;
  assign solo      = !busy && (req_mode == DM_SOLO);
  assign bad_len   = !busy && (req_mode == DM_SLOW) && mst_trig && (seq_len_m1 != '0);
  assign arm       = !busy && (req_mode != DM_SOLO) && mst_trig && !bad_len;
  assign spc_load  = arm && (req_mode == DM_FAST || req_mode == DM_SLOW);
  assign spc_gap   = CNT_W'(gap_for(req_mode, FAST_GAP, SLOW_GAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_mode   <= DM_SOLO;
      mst_start <= 1'b0;
      slv_start <= 1'b0;
      missed    <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      mst_start <= 1'b0;
      slv_start <= 1'b0;
      missed    <= missed  || drop_busy;
      cfg_err   <= cfg_err || bad_len;
      if (solo) begin
        mst_start <= mst_trig;
        slv_start <= slv_trig;
      end
      unique case (st)
        ST_IDLE: begin
          if (arm) begin
            slv_start <= 1'b1;
            op_mode   <= req_mode;
            if (req_mode == DM_SIMUL) begin
              mst_start <= 1'b1;
              st        <= ST_RUN;
            end else begin
              st <= ST_SPACE;
            end
          end
        end
        ST_SPACE: begin
          if (hit) begin
            mst_start <= 1'b1;
            st        <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_adc_coord.sv
module dual_adc_coord
  import dcc_pkg::*;
#(
  parameter int SEQ_W    = 4,
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_tick,
  input  logic [1:0]        mode,
  input  logic [SEQ_W-1:0]  seq_len_m1,
  input  logic              mst_trig,
  input  logic              slv_trig,
  output logic              mst_start,
  output logic              slv_start,
  input  logic              mst_done,
  input  logic [RES_W-1:0]  mst_res,
  input  logic              slv_done,
  input  logic [RES_W-1:0]  slv_res,
  output logic              dma_req,
  output logic [WORD_W-1:0] dma_word,
  output logic              missed,
  output logic              cfg_err
);
  localparam int CNT_W = $clog2(((FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP) + 1);

  // named internal events, also watched by the bound checker
  logic             busy, arm, spc_load, spc_hit, last_word, packed_op;
  logic [CNT_W-1:0] spc_gap;
  dual_mode_e       op_mode;

  assign packed_op = (op_mode == DM_SIMUL);

  dcc_ctrl #(
    .SEQ_W(SEQ_W), .FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .seq_len_m1(seq_len_m1),
    .mst_trig(mst_trig), .slv_trig(slv_trig), .hit(spc_hit), .last(last_word),
    .mst_start(mst_start), .slv_start(slv_start), .missed(missed), .cfg_err(cfg_err),
    .busy(busy), .op_mode(op_mode), .arm(arm), .spc_load(spc_load), .spc_gap(spc_gap)
  );

  dcc_spacer #(.CNT_W(CNT_W)) u_spacer (
    .clk(clk), .rst_n(rst_n), .load(spc_load), .gap(spc_gap),
    .tick(conv_tick), .hit(spc_hit)
  );

  dcc_collect u_collect (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .packed_op(packed_op),
    .mst_done(mst_done), .mst_res(mst_res), .slv_done(slv_done), .slv_res(slv_res),
    .dma_req(dma_req), .dma_word(dma_word), .last(last_word)
  );
endmodule

// File: rtl/dual_adc_coord_chk.sv
module dual_adc_coord_chk
  import dcc_pkg::*;
#(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_tick,
  input logic [1:0]        mode,
  input logic              mst_trig,
  input logic              busy,
  input dual_mode_e        op_mode,
  input logic              mst_start,
  input logic              slv_start,
  input logic              dma_req,
  input logic [WORD_W-1:0] dma_word,
  input logic              missed,
  input logic              cfg_err
);
  // ticks counted since the slave start
  logic [7:0] tk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tk_cnt <= '0;
    else if (slv_start) tk_cnt <= conv_tick ? 8'd1 : 8'd0;
    else if (conv_tick && tk_cnt != 8'hff) tk_cnt <= tk_cnt + 8'd1;
  end

  p_solo_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'd0 && mst_trig) |=> mst_start);

  p_pack_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && op_mode == DM_SIMUL) |->
      (dma_word[WORD_W-1:HALF_W+RES_W] == '0 && dma_word[HALF_W-1:RES_W] == '0));

  p_fast_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_start && busy && op_mode == DM_FAST) |-> (tk_cnt == 8'(FAST_GAP)));

  p_slow_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_start && busy && op_mode == DM_SLOW) |-> (tk_cnt == 8'(SLOW_GAP)));

  p_cfg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_lone_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && op_mode != DM_SIMUL) |-> (dma_word[WORD_W-1:RES_W] == '0));

  p_missed_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> missed);
endmodule

bind dual_adc_coord dual_adc_coord_chk #(
  .FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .mode(mode), .mst_trig(mst_trig),
  .busy(busy), .op_mode(op_mode), .mst_start(mst_start), .slv_start(slv_start),
  .dma_req(dma_req), .dma_word(dma_word), .missed(missed), .cfg_err(cfg_err)
);

// File: tb/dual_adc_coord_bench.sv
module dual_adc_coord_bench;
  localparam int NE   = 1300;
  localparam int STOP = 1150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_tick = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  seq_len_m1 = 4'd0;
  logic        mst_trig = 1'b0, slv_trig = 1'b0;
  logic        mst_start, slv_start, dma_req, missed, cfg_err;
  logic        mst_done = 1'b0, slv_done = 1'b0;
  logic [11:0] mst_res = '0, slv_res = '0;
  logic [31:0] dma_word;

  always #2 clk = ~clk; // 250 MHz

  dual_adc_coord u_dual_adc_coord (
    .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .mode(mode), .seq_len_m1(seq_len_m1),
    .mst_trig(mst_trig), .slv_trig(slv_trig), .mst_start(mst_start), .slv_start(slv_start),
    .mst_done(mst_done), .mst_res(mst_res), .slv_done(slv_done), .slv_res(slv_res),
    .dma_req(dma_req), .dma_word(dma_word), .missed(missed), .cfg_err(cfg_err)
  );

  int total = 0, bad = 0;
  int ec = 0;
  bit finished = 0;

  bit        trig_m [NE], trig_s [NE];
  int        seqlen [NE];
  bit        e_ms [NE], e_ss [NE], e_req [NE];
  bit [31:0] e_word [NE];
  bit        dm_at [NE], ds_at [NE];
  bit [11:0] dm_v [NE], ds_v [NE];
  int        missed_from = NE, cfg_from = NE, busy_until = -1;

  function automatic int mode_at(int e);
    if (e < 100) return 0;
    if (e < 300) return 1;
    if (e < 500) return 2;
    if (e < 600) return 3;
    if (e < 700) return 2;
    if (e < 900) return 3;
    return 0;
  endfunction
  function automatic bit tick_at(int e);
    return (e >= 600 && e < 900) ? (e % 2 == 0) : 1'b1;
  endfunction
  function automatic int latm(int e); return 14 + (e % 3) * 4; endfunction
  function automatic int lats(int e); return 14 + (e % 8); endfunction
  function automatic bit [11:0] val_m(int e); return 12'((e * 37 + 5) % 4096); endfunction
  function automatic bit [11:0] val_s(int e); return 12'((e * 53 + 900) % 4096); endfunction

  function automatic string tag(int e, int kind);
    int m = mode_at(e);
    if (e < 6)     return "R1";
    if (kind == 2) return "R9";
    if (kind == 3) return "R7";
    if (m == 0)    return "R2";
    if (m == 1)    return (kind == 1) ? "R4" : "R3";
    if (kind == 1) return "R8";
    return (m == 2) ? "R5" : "R6";
  endfunction

  // behavioural reference: one call per trigger edge, in time order
  task automatic model_trig(int e);
    int m = mode_at(e);
    int gap, c, n, ms, ds, dm, es, em, last;
    if (m == 0) begin
      if (e <= busy_until) begin
        if (missed_from > e) missed_from = e;
      end else begin
        e_ms[e] = trig_m[e];
        e_ss[e] = trig_s[e];
      end
      return;
    end
    if (!trig_m[e]) return;
    if (e <= busy_until) begin
      if (missed_from > e) missed_from = e;
      return;
    end
    if (m == 3 && seqlen[e] != 0) begin
      if (cfg_from > e) cfg_from = e;
      return;
    end
    e_ss[e] = 1;
    if (m == 1) ms = e;
    else begin
      gap = (m == 2) ? 7 : 14;
      c = e; n = 0;
      while (n < gap) begin c++; if (tick_at(c)) n++; end
      ms = c;
    end
    e_ms[ms] = 1;
    ds = e + lats(e);
    dm = ms + latm(ms);
    if (m == 1) begin
      last = ((ds > dm) ? ds : dm) + 1;
      e_req[last] = 1;
      e_word[last] = {4'h0, val_s(e), 4'h0, val_m(ms)};
    end else begin
      es = ds + 1;
      em = (dm == ds) ? ds + 2 : dm + 1;
      e_req[es] = 1; e_word[es] = {20'h0, val_s(e)};
      e_req[em] = 1; e_word[em] = {20'h0, val_m(ms)};
      last = (es > em) ? es : em;
    end
    busy_until = last;
  endtask

  task automatic chk(bit ok, string t, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", t, what, ec, act, exp);
    end
  endtask

  always @(posedge clk) ec <= ec + 1;

  // compare, answer starts and drive the next edge's inputs
  always @(negedge clk) begin
    if (ec >= 1 && ec < STOP && !finished) begin
      chk(mst_start == e_ms[ec], tag(ec, 0), "mst_start", mst_start, e_ms[ec]);
      chk(slv_start == e_ss[ec], tag(ec, 0), "slv_start", slv_start, e_ss[ec]);
      chk(dma_req == e_req[ec], tag(ec, 1), "dma_req", dma_req, e_req[ec]);
      if (e_req[ec]) chk(dma_word == e_word[ec], tag(ec, 1), "dma_word", dma_word, e_word[ec]);
      chk(missed == (ec >= missed_from), tag(ec, 2), "missed", missed, ec >= missed_from);
      chk(cfg_err == (ec >= cfg_from), tag(ec, 3), "cfg_err", cfg_err, ec >= cfg_from);
      if (mst_start && ec + 30 < NE) begin
        dm_at[ec + latm(ec)] = 1; dm_v[ec + latm(ec)] = val_m(ec);
      end
      if (slv_start && ec + 30 < NE) begin
        ds_at[ec + lats(ec)] = 1; ds_v[ec + lats(ec)] = val_s(ec);
      end
    end
    if (ec + 1 < NE) begin
      if (ec == 3) rst_n <= 1'b1;
      mode       <= 2'(mode_at(ec + 1));
      conv_tick  <= tick_at(ec + 1);
      mst_trig   <= trig_m[ec + 1];
      slv_trig   <= trig_s[ec + 1];
      seq_len_m1 <= 4'(seqlen[ec + 1]);
      mst_done   <= dm_at[ec + 1];
      mst_res    <= dm_at[ec + 1] ? dm_v[ec + 1] : 12'h0;
      slv_done   <= ds_at[ec + 1];
      slv_res    <= ds_at[ec + 1] ? ds_v[ec + 1] : 12'h0;
    end
  end

  initial begin
    // R2 solo passthrough
    trig_m[10] = 1; trig_s[12] = 1; trig_m[15] = 1; trig_s[15] = 1;
    // R3/R4 simultaneous, with triggers inside and at the end of the busy window (R9)
    trig_m[100] = 1; trig_m[105] = 1; trig_m[119] = 1; trig_m[120] = 1; trig_m[200] = 1;
    // R5/R8 fast; edge 311 makes both done pulses coincide
    trig_m[300] = 1; trig_m[311] = 1; trig_m[360] = 1;
    // R6 slow, R7 refused group length
    trig_m[500] = 1; trig_m[560] = 1; seqlen[560] = 3; trig_m[570] = 1;
    // halved tick rate
    trig_m[620] = 1; trig_m[700] = 1; trig_m[705] = 1;
    // back to solo
    trig_m[950] = 1; trig_s[950] = 1; trig_s[960] = 1; slv_trig = 0;
    for (int e = 4; e < STOP; e++) if (trig_m[e] || trig_s[e]) model_trig(e);
    wait (ec >= STOP);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R1 expired: actual=%0d expected=%0d", ec, STOP);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule